// File: doc/BRIEF.md
# Wakeup Interrupt Monitor

This block stays powered while the rest of the chip sleeps and watches a set of wakeup pins. Each pin can be set to latch an event on a low-to-high change, a high-to-low change, either change, or, when neither edge is selected, while its level matches a chosen polarity. A latched event sets a per-pin status bit. A pin is pending when its status bit and its enable bit are both set. A single registered wake output goes high while any pin is pending.

Software reaches the block through a plain 32-bit register port: a byte address, a write strobe, write data and combinational read data. Two scratch timer words sit at the bottom of the map. They are followed by five per-pin bit banks, each one word per 32 pins: enable, falling, rising, polarity and status. Software loads the banks while the system is awake. It clears the status bank before sleep, and after wakeup it reads the status bank to see which pins fired.

Top module: `wakeup_monitor`

## Requirements
- R1: After reset, every timer and bank word reads zero and wake_o is low.
- R2: The words at byte addresses 0x00 and 0x04 are 32-bit read/write storage with no effect on pin handling.
- R3: With S = ceil(NPINS/32), word i of bank b sits at byte address (b*S + i + 2)*4. The bank numbers are enable 0, falling 1, rising 2, polarity 3 and status 4. Pin p uses bit p%32 of word p/32 in every bank. Address bits [1:0] are ignored.
- R4: Bank bits for pin numbers NPINS and above read as zero, and writes to them are dropped.
- R5: A read from a word address at or beyond 5*S+2 returns zero, and a write there changes no register.
- R6: A pin with its rising bit set latches its status bit on a low-to-high change of the synchronised input.
- R7: A pin with its falling bit set latches its status bit on a high-to-low change. It does not latch on a low-to-high change unless its rising bit is also set.
- R8: A pin with both edge bits set latches on either change, and no edge-mode pin latches while its input is steady.
- R9: A pin with both edge bits clear latches its status bit in every cycle in which its input equals its polarity bit (1 for high, 0 for low).
- R10: Events latch only for pins whose enable bit is set. A disabled pin's status bit does not change except by a write.
- R11: Each input passes through two synchroniser flops. A change applied before clock edge E1 appears in status after edge E3. wake_o, which is the registered OR of status AND enable, follows one edge later.
- R12: Status bits stay set until software writes the status word, and the written value replaces the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_i | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pins_i | input | NPINS | Asynchronous wakeup pin inputs |
| wake_o | output | 1 | Registered wake request |

## Verification
The bench builds the block with NPINS = 40 and ADDR_W = 7. This gives two words per bank, so a pin number above 31 exercises the word index of the address formula. The second word is only partly populated, so the unimplemented upper bits of R4 are within reach. A 128-byte space leaves twenty word addresses past the last status word for R5. Directed cases on pin 35 cover each detection mode and the exact synchroniser latency. Seeded random configurations with one transition per pin then cover all pins at once, and the bench checks the result against a function of the configuration and the before and after pin values.

// File: rtl/wim_pkg.sv
package wim_pkg;
   localparam int WORD_W      = 32;
   localparam int NUM_BANKS   = 5;
   localparam int TIMER_WORDS = 2;

   typedef enum logic [2:0] {
      BANK_EN   = 3'd0,
      BANK_FALL = 3'd1,
      BANK_RISE = 3'd2,
      BANK_POL  = 3'd3,
      BANK_STAT = 3'd4
   } bank_e;

   function automatic int words_for(input int pins);
      return (pins + WORD_W - 1) / WORD_W;
   endfunction
endpackage

// File: rtl/wim_sync.sv
module wim_sync #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   logic [W-1:0] meta_q, cur_q, prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         meta_q <= '0;
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= d_i;
         cur_q  <= meta_q;
         prev_q <= cur_q;
      end
   end

   assign cur_o  = cur_q;
   assign prev_o = prev_q;
endmodule

// File: rtl/wim_event.sv
module wim_event #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] rise_i,
   input  logic [W-1:0] fall_i,
   input  logic [W-1:0] pol_i,
   output logic [W-1:0] evt_o
);
   for (genvar j = 0; j < W; j++) begin : g_pin
      logic up, down, lvl_mode, lvl_hit;
      assign up       = cur_i[j] & ~prev_i[j];
      assign down     = ~cur_i[j] & prev_i[j];
      assign lvl_mode = ~rise_i[j] & ~fall_i[j];
      assign lvl_hit  = ~(cur_i[j] ^ pol_i[j]);
      assign evt_o[j] = (rise_i[j] & up) | (fall_i[j] & down) | (lvl_mode & lvl_hit);
   end
endmodule

// File: rtl/wim_decode.sv
module wim_decode #(
   parameter int ADDR_W = 8,
   parameter int NWORDS = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NWORDS-1:0] hit_o
);
   logic [ADDR_W-3:0] word_idx;
   logic              unused_low;

   assign word_idx   = addr_i[ADDR_W-1:2];
   assign unused_low = ^addr_i[1:0];

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      assign hit_o[k] = (32'(word_idx) == 32'(k));
   end
endmodule

// File: rtl/wakeup_monitor.sv
module wakeup_monitor #(
   parameter int NPINS  = 48,
   parameter int ADDR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic [NPINS-1:0]  pins_i,
   output logic              wake_o
);
   import wim_pkg::*;

   localparam int STRIDE = words_for(NPINS);
   localparam int BITS   = STRIDE * WORD_W;
   localparam int NWORDS = TIMER_WORDS + NUM_BANKS * STRIDE;

   function automatic logic [BITS-1:0] pin_mask_f();
      logic [BITS-1:0] m;
      for (int j = 0; j < BITS; j++) m[j] = (j < NPINS);
      return m;
   endfunction
   localparam logic [BITS-1:0] PIN_MASK = pin_mask_f();

   if (NPINS < 1) begin : g_bad_pins
      $error("wakeup_monitor: NPINS must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
      $error("wakeup_monitor: ADDR_W must lie in 3..32");
   end
   if (longint'(NWORDS) * 4 > (longint'(1) << ADDR_W)) begin : g_bad_map
      $error("wakeup_monitor: ADDR_W too small for the register map");
   end

   logic [NWORDS-1:0]             word_hit, wr_hit;
   logic [1:0][31:0]              timer_q;
   logic [NUM_BANKS-1:0][BITS-1:0] bank_q;
   logic [NPINS-1:0]              pin_cur, pin_prev, pin_evt;
   logic [BITS-1:0]               evt_ext;

   wim_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
      .addr_i (addr_i),
      .hit_o  (word_hit)
   );
   assign wr_hit = word_hit & {NWORDS{we_i}};

   wim_sync #(.W(NPINS)) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .d_i    (pins_i),
      .cur_o  (pin_cur),
      .prev_o (pin_prev)
   );

   wim_event #(.W(NPINS)) u_evt (
      .cur_i  (pin_cur),
      .prev_i (pin_prev),
      .rise_i (bank_q[BANK_RISE][NPINS-1:0]),
      .fall_i (bank_q[BANK_FALL][NPINS-1:0]),
      .pol_i  (bank_q[BANK_POL][NPINS-1:0]),
      .evt_o  (pin_evt)
   );

   if (BITS > NPINS) begin : g_evt_pad
      assign evt_ext = {{(BITS-NPINS){1'b0}}, pin_evt};
   end else begin : g_evt_full
      assign evt_ext = pin_evt;
   end

   for (genvar t = 0; t < TIMER_WORDS; t++) begin : g_timer
      always_ff @(posedge clk_i) begin
         if (rst_i)          timer_q[t] <= '0;
         else if (wr_hit[t]) timer_q[t] <= wdata_i;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BITS-1:0] wmask, wval, merged, nxt, reg_q;
      for (genvar i = 0; i < STRIDE; i++) begin : g_word
         assign wmask[i*WORD_W +: WORD_W] = {WORD_W{wr_hit[TIMER_WORDS + b*STRIDE + i]}};
         assign wval[i*WORD_W +: WORD_W]  = wdata_i;
      end
      assign merged = (reg_q & ~wmask) | (wval & wmask);

      if (b == int'(BANK_STAT)) begin : g_status
         assign nxt = (merged | (evt_ext & bank_q[BANK_EN])) & PIN_MASK;
      end else begin : g_plain
         assign nxt = merged & PIN_MASK;
      end

      always_ff @(posedge clk_i) begin
         if (rst_i) reg_q <= '0;
         else       reg_q <= nxt;
      end
      assign bank_q[b] = reg_q;
   end

   always_comb begin
      rdata_o = '0;
      for (int t = 0; t < TIMER_WORDS; t++)
         if (word_hit[t]) rdata_o |= timer_q[t];
      for (int b = 0; b < NUM_BANKS; b++)
         for (int i = 0; i < STRIDE; i++)
            if (word_hit[TIMER_WORDS + b*STRIDE + i])
               rdata_o |= bank_q[b][i*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) wake_o <= 1'b0;
      else       wake_o <= |(bank_q[BANK_STAT] & bank_q[BANK_EN]);
   end
endmodule

// File: rtl/wakeup_monitor_chk.sv
module wakeup_monitor_chk #(
   parameter int NPINS  = 48,
   parameter int ADDR_W = 8
) (
   input logic                     clk_i,
   input logic                     rst_i,
   input logic                     we_i,
   input logic [ADDR_W-3:0]        word_i,
   input logic                     wake_o,
   input logic [1:0][31:0]         timer_q,
   input logic [4:0][wim_pkg::words_for(NPINS)*32-1:0] bank_q
);
   localparam int STRIDE = wim_pkg::words_for(NPINS);
   localparam int NWORDS = 2 + 5 * STRIDE;

   logic oor;
   assign oor = (32'(word_i) >= 32'(NWORDS));

   // R1: state right after reset release
   assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (!wake_o && bank_q == '0 && timer_q == '0));

   // R5: out-of-range writes leave configuration and timers untouched
   assert_oor_write_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (we_i && oor) |=> ($stable(timer_q) && $stable(bank_q[3:0])));

   // R10: a status bit rises only for a pin enabled in the prior cycle
   assert_enable_gate_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !we_i |=> ((bank_q[4] & ~$past(bank_q[4]) & ~$past(bank_q[0])) == '0));

   // R12: without a write, status bits never clear
   assert_status_sticky_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      !we_i |=> (($past(bank_q[4]) & ~bank_q[4]) == '0));

   // R11: wake follows pending state one edge later
   assert_wake_rise_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (|(bank_q[4] & bank_q[0])) |=> wake_o);
   assert_wake_fall_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      !(|(bank_q[4] & bank_q[0])) |=> !wake_o);
endmodule

bind wakeup_monitor wakeup_monitor_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .we_i    (we_i),
   .word_i  (addr_i[ADDR_W-1:2]),
   .wake_o  (wake_o),
   .timer_q (timer_q),
   .bank_q  (bank_q)
);

// File: tb/tb_wakeup_monitor.sv
module tb_wakeup_monitor;
   localparam int CLK_P = 10;
   localparam int NP    = 40;
   localparam int AW    = 7;
   localparam int S     = (NP + 31) / 32;
   localparam int BW    = S * 32;
   localparam int NW    = 2 + 5 * S;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pins = '0;
   logic          wake;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wakeup_monitor #(.NPINS(NP), .ADDR_W(AW)) dut (
      .clk_i (clk), .rst_i (rst), .we_i (we), .addr_i (addr),
      .wdata_i (wdata), .rdata_o (rdata), .pins_i (pins), .wake_o (wake)
   );

   function automatic logic [BW-1:0] mask_f();
      logic [BW-1:0] m;
      for (int j = 0; j < BW; j++) m[j] = (j < NP);
      return m;
   endfunction
   localparam logic [BW-1:0] MASK = mask_f();

   function automatic int baddr(int b, int i);
      return (b * S + i + 2) * 4;
   endfunction

   function automatic logic [BW-1:0] exp_stat(logic [BW-1:0] en, logic [BW-1:0] ri,
                                              logic [BW-1:0] fa, logic [BW-1:0] po,
                                              logic [BW-1:0] a, logic [BW-1:0] b);
      logic [BW-1:0] lvl;
      lvl = ~ri & ~fa;
      return en & MASK & ((lvl & (~(a ^ po) | ~(b ^ po))) | (ri & ~a & b) | (fa & a & ~b));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk); we = 1'b0; addr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(int p, logic v);
      @(negedge clk); pins[p] = v;
   endtask

   task automatic clr_stat();
      for (int i = 0; i < S; i++) wr(baddr(4, i), 32'h0);
   endtask

   task automatic stat_is(string req, logic [31:0] exp);
      logic [31:0] d;
      rd(baddr(4, 1), d);
      chk(req, d, exp);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] pat [NW];
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;

      // R1: reset contents
      for (int w = 0; w < NW; w++) begin
         rd(w * 4, d);
         chk("R1 reset word", d, 32'h0);
      end
      chk("R1 wake after reset", {31'b0, wake}, 32'h0);

      // R2: timer words
      wr(0, 32'hDEADBEEF);
      wr(4, 32'h13572468);
      rd(0, d); chk("R2 timer0", d, 32'hDEADBEEF);
      rd(4, d); chk("R2 timer1", d, 32'h13572468);

      // R3 / R4: enable bank placement and masking, then clear it
      wr(baddr(0, 0), 32'hC3C3A5A5);
      wr(baddr(0, 1), 32'hFFFFFF5A);
      rd(baddr(0, 0), d); chk("R3 enable word0", d, 32'hC3C3A5A5);
      rd(baddr(0, 1), d); chk("R4 enable word1 upper bits", d, 32'h0000005A);
      wr(baddr(0, 0), 32'h0);
      wr(baddr(0, 1), 32'h0);
      // R3 / R4: remaining banks with distinct patterns (enable is zero)
      for (int b = 1; b < 5; b++)
         for (int i = 0; i < S; i++)
            wr(baddr(b, i), 32'h1F2E3D00 ^ (32'(b) << 4) ^ 32'(i) ^ (32'(b) << 20));
      for (int b = 1; b < 5; b++)
         for (int i = 0; i < S; i++) begin
            logic [31:0] e;
            e = 32'h1F2E3D00 ^ (32'(b) << 4) ^ 32'(i) ^ (32'(b) << 20);
            if (i == S - 1) e = e & MASK[BW-1 -: 32];
            rd(baddr(b, i), d);
            chk("R3 bank word placement", d, e);
         end
      // R5: out-of-range accesses
      for (int w = 0; w < NW; w++) rd(w * 4, pat[w]);
      wr(NW * 4, 32'hFFFFFFFF);
      wr((1 << AW) - 4, 32'hFFFFFFFF);
      rd(NW * 4, d);           chk("R5 read first unmapped", d, 32'h0);
      rd((1 << AW) - 4, d);    chk("R5 read last unmapped", d, 32'h0);
      for (int w = 0; w < NW; w++) begin
         rd(w * 4, d);
         chk("R5 mapped word unchanged", d, pat[w]);
      end
      for (int b = 1; b < 5; b++)
         for (int i = 0; i < S; i++) wr(baddr(b, i), 32'h0);

      // R6 / R11: rising edge on pin 35 (word 1 bit 3) with latency
      wr(baddr(2, 1), 32'h8);
      wr(baddr(0, 1), 32'h8);
      clr_stat();
      cyc(4);
      @(negedge clk); pins[35] = 1'b1;
      @(posedge clk); @(posedge clk); #1 addr = AW'(baddr(4, 1));
      #1 chk("R11 status not yet set after two edges", rdata, 32'h0);
      @(posedge clk); #1 chk("R6 rising latched after third edge", rdata, 32'h8);
      chk("R11 wake still low after third edge", {31'b0, wake}, 32'h0);
      @(posedge clk); #1 chk("R11 wake high after fourth edge", {31'b0, wake}, 32'h1);

      // R12: sticky, then cleared by write
      set_pin(35, 1'b0); cyc(6);
      stat_is("R12 status held after pin drops", 32'h8);
      clr_stat(); cyc(3);
      stat_is("R12 status cleared by write", 32'h0);
      chk("R12 wake low after clear", {31'b0, wake}, 32'h0);

      // R7: falling only
      wr(baddr(1, 1), 32'h8);
      wr(baddr(2, 1), 32'h0);
      clr_stat();
      set_pin(35, 1'b1); cyc(6);
      stat_is("R7 rising ignored in falling mode", 32'h0);
      set_pin(35, 1'b0); cyc(6);
      stat_is("R7 falling latched", 32'h8);

      // R8: both edges
      wr(baddr(2, 1), 32'h8);
      clr_stat();
      set_pin(35, 1'b1); cyc(6);
      stat_is("R8 rise in both mode", 32'h8);
      clr_stat(); cyc(6);
      stat_is("R8 steady high no latch", 32'h0);
      set_pin(35, 1'b0); cyc(6);
      stat_is("R8 fall in both mode", 32'h8);

      // R9: level sensing
      wr(baddr(1, 1), 32'h0);
      wr(baddr(2, 1), 32'h0);
      wr(baddr(3, 1), 32'h8);
      clr_stat(); cyc(6);
      stat_is("R9 low input, active-high no latch", 32'h0);
      set_pin(35, 1'b1); cyc(6);
      stat_is("R9 high input latches", 32'h8);
      clr_stat(); cyc(2);
      stat_is("R9 relatched while level holds", 32'h8);
      wr(baddr(3, 1), 32'h0);
      set_pin(35, 1'b0); cyc(4);
      clr_stat(); cyc(2);
      stat_is("R9 active-low level latches", 32'h8);

      // R10: disabled pin does not latch
      wr(baddr(0, 1), 32'h0);
      clr_stat(); cyc(6);
      stat_is("R10 disabled level pin stays clear", 32'h0);
      chk("R10 wake low with pin disabled", {31'b0, wake}, 32'h0);

      // R6-R10: seeded random configurations, one transition per pin
      for (int t = 0; t < 24; t++) begin
         logic [BW-1:0] en, ri, fa, po, a, b, ex;
         en = {$urandom, $urandom} & MASK;
         ri = {$urandom, $urandom} & MASK;
         fa = {$urandom, $urandom} & MASK;
         po = {$urandom, $urandom} & MASK;
         a  = {$urandom, $urandom} & MASK;
         b  = {$urandom, $urandom} & MASK;
         if (t == 0) begin a = '0; b = MASK; end
         if (t == 1) begin a = MASK; b = '0; en = MASK; end
         @(negedge clk); pins = a[NP-1:0];
         cyc(5);
         for (int i = 0; i < S; i++) begin
            wr(baddr(1, i), fa[i*32 +: 32]);
            wr(baddr(2, i), ri[i*32 +: 32]);
            wr(baddr(3, i), po[i*32 +: 32]);
            wr(baddr(0, i), en[i*32 +: 32]);
         end
         clr_stat(); cyc(3);
         @(negedge clk); pins = b[NP-1:0];
         cyc(6);
         ex = exp_stat(en, ri, fa, po, a, b);
         for (int i = 0; i < S; i++) begin
            rd(baddr(4, i), d);
            chk("R6-R10 random status word", d, ex[i*32 +: 32]);
         end
         chk("R11 random wake", {31'b0, wake}, {31'b0, |ex});
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule